// File: doc/BRIEF.md
# Link Fault Detector and Responder for a 32-bit Ten-Gigabit Media Interface

This block sits at the reconciliation layer of a ten-gigabit Ethernet port, on the 32-bit, four-lane media interface. It inspects every receive column for fault ordered sets. A column carrying a local fault or a remote fault indication feeds a per-type counter that runs inside a bounded window of columns. Enough indications of one type inside that window move the link fault state to that type. A long enough stretch with no indication returns the state to OK.

The same state steers the transmit path toward the PHY. In the OK state the MAC's transmit columns pass through unchanged. When a local fault is held, the block answers the far end by sending remote fault ordered sets on every column. When a remote fault is held, MAC traffic is replaced by idle columns. The present state is also driven out as a two-bit status code.

Top module: `lfm_link_fault_mon`

## Requirements
- R1: A receive column is a fault ordered set only when the control nibble is 4'b0001, byte lane 0 (bits [7:0]) is 0x9C, lanes 1 and 2 are 0x00, and lane 3 (bits [31:24]) is 0x01 (local fault) or 0x02 (remote fault). Any other column, including near misses, counts as a non-fault column.
- R2: When four local fault sets arrive with the first and fourth no more than 127 columns apart, the status becomes local fault (code 2'b01) from the clock edge that samples the fourth set.
- R3: When four remote fault sets arrive with the first and fourth no more than 127 columns apart, the status becomes remote fault (code 2'b10) from the clock edge that samples the fourth set.
- R4: A count that has spanned 128 columns without reaching four expires. A set that arrives 128 or more columns after the first set of its run starts a new run and does not change the status.
- R5: A fault set of the other type discards the running count and starts a new count of one for the new type.
- R6: After 128 consecutive non-fault columns, the status returns to OK (code 2'b00). With 127 such columns the status is held.
- R7: While the status is local fault, the transmit output is data 0x0200009C with control 0x1 on every column, whatever the MAC drives.
- R8: While the status is remote fault, the transmit output is an idle column: data 0x07070707 with control 0xF.
- R9: While the status is OK, the transmit data and control equal the MAC's transmit data and control in the same cycle.
- R10: An active-low reset sets the status to OK and discards any partial count, so a single set after reset does not complete a run started before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Column clock; one 32-bit column per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Receive column data, lane 0 in bits [7:0] |
| rx_ctrl | input | 4 | Receive control flags, one per byte lane |
| mac_tx_data | input | 32 | Transmit column data from the MAC |
| mac_tx_ctrl | input | 4 | Transmit control flags from the MAC |
| phy_tx_data | output | 32 | Transmit column data toward the PHY |
| phy_tx_ctrl | output | 4 | Transmit control flags toward the PHY |
| fault_status | output | 2 | Link state: 00 OK, 01 local fault, 10 remote fault |

## Verification
The bench builds the block with its default values: a 128-column window, a threshold of four and four lanes. These are the only values at which the window edge and the quiet-time edge can be checked against exact column counts. At these values a run whose fourth set lands 127 columns after the first, one that lands 128 columns after it, and a quiet stretch of 127 against 128 columns all fit in a few hundred cycles. Random mixes of both fault types with idle gaps then reach type switches and repeated entries and exits.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    LFM_OK     = 2'b00,
    LFM_LOCAL  = 2'b01,
    LFM_REMOTE = 2'b10
  } lfm_state_e;

  localparam logic [LANE_W-1:0] SEQ_CHAR    = 8'h9C;
  localparam logic [LANE_W-1:0] IDLE_CHAR   = 8'h07;
  localparam logic [LANE_W-1:0] CODE_LOCAL  = 8'h01;
  localparam logic [LANE_W-1:0] CODE_REMOTE = 8'h02;

endpackage

// File: rtl/lfm_col_decode.sv
module lfm_col_decode
  import lfm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*LANE_W-1:0] col_data,
  input  logic [LANES-1:0]        col_ctrl,
  output logic                    is_fault,
  output logic                    is_remote
);

  logic [LANES-1:0]  lane_ok;
  logic [LANE_W-1:0] code;

  assign code = col_data[(LANES-1)*LANE_W +: LANE_W];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_head
      assign lane_ok[i] = col_ctrl[i] && (col_data[i*LANE_W +: LANE_W] == SEQ_CHAR);
    end else if (i == LANES-1) begin : g_code
      assign lane_ok[i] = !col_ctrl[i];
    end else begin : g_pad
      assign lane_ok[i] = !col_ctrl[i] && (col_data[i*LANE_W +: LANE_W] == '0);
    end
  end

  assign is_fault  = (&lane_ok) && ((code == CODE_LOCAL) || (code == CODE_REMOTE));
  assign is_remote = (code == CODE_REMOTE);

endmodule

// File: rtl/lfm_window.sv
module lfm_window
  import lfm_pkg::*;
#(
  parameter int WINDOW = 128,
  parameter int THRESH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_fault,
  input  logic       is_remote,
  output lfm_state_e state
);

  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam int CNT_W = $clog2(THRESH + 1);
  localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(WINDOW);
  localparam logic [WIN_W-1:0] QUIET_END = WIN_W'(WINDOW - 1);
  localparam logic [CNT_W-1:0] CNT_HIT   = CNT_W'(THRESH);

  lfm_state_e       state_q, state_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [WIN_W-1:0] quiet_q, quiet_d;
  logic             type_q, type_d;
  logic             run_live;
  logic [CNT_W-1:0] run_inc;

  assign run_live = (run_q != '0) && (win_q != WIN_LAST);
  assign run_inc  = run_q + CNT_W'(1);

  always_comb begin
    state_d = state_q;
    run_d   = run_live ? run_q : '0;
    win_d   = win_q;
    type_d  = type_q;
    quiet_d = quiet_q;
    if (is_fault) begin
      quiet_d = '0;
      if (!run_live || (is_remote != type_q)) begin
        run_d  = CNT_W'(1);
        win_d  = WIN_W'(1);
        type_d = is_remote;
      end else begin
        run_d = run_inc;
        win_d = win_q + WIN_W'(1);
        if (run_inc == CNT_HIT) begin
          state_d = is_remote ? LFM_REMOTE : LFM_LOCAL;
          run_d   = '0;
        end
      end
    end else begin
      if (run_live) begin
        win_d = win_q + WIN_W'(1);
      end
      if (quiet_q != WIN_LAST) begin
        quiet_d = quiet_q + WIN_W'(1);
      end
      if (quiet_q == QUIET_END) begin
        state_d = LFM_OK;
        run_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LFM_OK;
      run_q   <= '0;
      win_q   <= '0;
      quiet_q <= '0;
      type_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      win_q   <= win_d;
      quiet_q <= quiet_d;
      type_q  <= type_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/lfm_tx_sel.sv
module lfm_tx_sel
  import lfm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  lfm_state_e              state,
  input  logic [LANES*LANE_W-1:0] mac_data,
  input  logic [LANES-1:0]        mac_ctrl,
  output logic [LANES*LANE_W-1:0] out_data,
  output logic [LANES-1:0]        out_ctrl
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] rf_byte;
    logic              rf_ctl;
    if (i == 0) begin : g_head
      assign rf_byte = SEQ_CHAR;
      assign rf_ctl  = 1'b1;
    end else if (i == LANES-1) begin : g_code
      assign rf_byte = CODE_REMOTE;
      assign rf_ctl  = 1'b0;
    end else begin : g_pad
      assign rf_byte = '0;
      assign rf_ctl  = 1'b0;
    end

    always_comb begin
      unique case (state)
        LFM_LOCAL: begin
          out_data[i*LANE_W +: LANE_W] = rf_byte;
          out_ctrl[i]                  = rf_ctl;
        end
        LFM_REMOTE: begin
          out_data[i*LANE_W +: LANE_W] = IDLE_CHAR;
          out_ctrl[i]                  = 1'b1;
        end
        default: begin
          out_data[i*LANE_W +: LANE_W] = mac_data[i*LANE_W +: LANE_W];
          out_ctrl[i]                  = mac_ctrl[i];
        end
      endcase
    end
  end

endmodule

// File: rtl/lfm_link_fault_mon.sv
module lfm_link_fault_mon
  import lfm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WINDOW = 128,
  parameter int THRESH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] rx_data,
  input  logic [LANES-1:0]        rx_ctrl,
  input  logic [LANES*LANE_W-1:0] mac_tx_data,
  input  logic [LANES-1:0]        mac_tx_ctrl,
  output logic [LANES*LANE_W-1:0] phy_tx_data,
  output logic [LANES-1:0]        phy_tx_ctrl,
  output logic [1:0]              fault_status
);

  logic       col_fault;
  logic       col_remote;
  lfm_state_e link_state;

  lfm_col_decode #(.LANES(LANES)) u_decode (
    .col_data  (rx_data),
    .col_ctrl  (rx_ctrl),
    .is_fault  (col_fault),
    .is_remote (col_remote)
  );

  lfm_window #(.WINDOW(WINDOW), .THRESH(THRESH)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_fault  (col_fault),
    .is_remote (col_remote),
    .state     (link_state)
  );

  lfm_tx_sel #(.LANES(LANES)) u_tx (
    .state    (link_state),
    .mac_data (mac_tx_data),
    .mac_ctrl (mac_tx_ctrl),
    .out_data (phy_tx_data),
    .out_ctrl (phy_tx_ctrl)
  );

  assign fault_status = link_state;

endmodule

// File: rtl/lfm_checker.sv
module lfm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rx_data,
  input logic [3:0]  rx_ctrl,
  input logic [31:0] mac_tx_data,
  input logic [3:0]  mac_tx_ctrl,
  input logic [31:0] phy_tx_data,
  input logic [3:0]  phy_tx_ctrl,
  input logic [1:0]  fault_status
);

  a_r10_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fault_status != 2'b11);

  a_r2_enter_local: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_status == 2'b01 && $past(fault_status) != 2'b01)
      |-> ($past(rx_ctrl) == 4'h1 && $past(rx_data) == 32'h0100009C));

  a_r3_enter_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_status == 2'b10 && $past(fault_status) != 2'b10)
      |-> ($past(rx_ctrl) == 4'h1 && $past(rx_data) == 32'h0200009C));

  a_r6_clear_on_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_status == 2'b00 && $past(fault_status) != 2'b00)
      |-> !($past(rx_ctrl) == 4'h1 && $past(rx_data[23:0]) == 24'h00009C));

  a_r7_send_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_status == 2'b01) |-> (phy_tx_data == 32'h0200009C && phy_tx_ctrl == 4'h1));

  a_r8_send_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_status == 2'b10) |-> (phy_tx_data == 32'h07070707 && phy_tx_ctrl == 4'hF));

  a_r9_pass_mac: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_status == 2'b00) |-> (phy_tx_data == mac_tx_data && phy_tx_ctrl == mac_tx_ctrl));

endmodule

bind lfm_link_fault_mon lfm_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_data      (rx_data),
  .rx_ctrl      (rx_ctrl),
  .mac_tx_data  (mac_tx_data),
  .mac_tx_ctrl  (mac_tx_ctrl),
  .phy_tx_data  (phy_tx_data),
  .phy_tx_ctrl  (phy_tx_ctrl),
  .fault_status (fault_status)
);

// File: tb/sim_lfm_link_fault_mon.sv
module sim_lfm_link_fault_mon;

  localparam logic [31:0] LF_SET = 32'h0100009C;
  localparam logic [31:0] RF_SET = 32'h0200009C;
  localparam logic [31:0] IDLE   = 32'h07070707;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] rx_data, mac_tx_data, phy_tx_data;
  logic [3:0]  rx_ctrl, mac_tx_ctrl, phy_tx_ctrl;
  logic [1:0]  fault_status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_state, m_type, m_run, m_win, m_quiet;

  always #5 clk = ~clk;

  lfm_link_fault_mon u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .mac_tx_data(mac_tx_data), .mac_tx_ctrl(mac_tx_ctrl),
    .phy_tx_data(phy_tx_data), .phy_tx_ctrl(phy_tx_ctrl),
    .fault_status(fault_status)
  );

  function automatic int fault_kind(input logic [31:0] d, input logic [3:0] c);
    if (c == 4'h1 && d[23:0] == 24'h00009C && d[31:24] == 8'h01) return 1;
    if (c == 4'h1 && d[23:0] == 24'h00009C && d[31:24] == 8'h02) return 2;
    return 0;
  endfunction

  task automatic model_reset();
    m_state = 0; m_type = 0; m_run = 0; m_win = 0; m_quiet = 0;
  endtask

  task automatic model_step(input logic [31:0] d, input logic [3:0] c);
    int k;
    k = fault_kind(d, c);
    if (m_run != 0 && m_win == 128) m_run = 0;
    if (k != 0) begin
      m_quiet = 0;
      if (m_run == 0 || k != m_type) begin
        m_type = k; m_run = 1; m_win = 1;
      end else begin
        m_run++; m_win++;
        if (m_run == 4) begin m_state = k; m_run = 0; end
      end
    end else begin
      if (m_run != 0) m_win++;
      if (m_quiet == 127) begin m_state = 0; m_run = 0; end
      if (m_quiet < 128) m_quiet++;
    end
  endtask

  task automatic check_out(input string tag);
    logic [31:0] ed;
    logic [3:0]  ec;
    string       ttag;
    checks++;
    if (fault_status !== 2'(m_state)) begin
      fails++;
      $display("FAIL %s status: got %0d expected %0d", tag, fault_status, m_state);
    end
    if (m_state == 1) begin ed = RF_SET; ec = 4'h1; ttag = "R7"; end
    else if (m_state == 2) begin ed = IDLE; ec = 4'hF; ttag = "R8"; end
    else begin ed = mac_tx_data; ec = mac_tx_ctrl; ttag = "R9"; end
    checks++;
    if (phy_tx_data !== ed || phy_tx_ctrl !== ec) begin
      fails++;
      $display("FAIL %s tx: got %h/%h expected %h/%h", ttag, phy_tx_data, phy_tx_ctrl, ed, ec);
    end
  endtask

  task automatic expect_status(input int exp, input string tag);
    checks++;
    if (fault_status !== 2'(exp)) begin
      fails++;
      $display("FAIL %s directed status: got %0d expected %0d", tag, fault_status, exp);
    end
  endtask

  task automatic col(input logic [31:0] d, input logic [3:0] c, input string tag);
    rx_data = d; rx_ctrl = c;
    mac_tx_data = $urandom; mac_tx_ctrl = 4'($urandom);
    @(posedge clk);
    model_step(d, c);
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic gap(input int n, input string tag);
    for (int i = 0; i < n; i++) col(IDLE, 4'hF, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    check_out("R10");
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rx_data = IDLE; rx_ctrl = 4'hF; mac_tx_data = '0; mac_tx_ctrl = '0;
    @(negedge clk);
    do_reset();
    expect_status(0, "R10");

    // R2: fourth local set exactly 127 columns after the first
    col(LF_SET, 4'h1, "R2"); gap(42, "R2");
    col(LF_SET, 4'h1, "R2"); gap(42, "R2");
    col(LF_SET, 4'h1, "R2"); gap(40, "R2");
    col(LF_SET, 4'h1, "R2");
    expect_status(1, "R2");

    // R6: 127 quiet columns hold, the 128th clears
    gap(127, "R6");
    expect_status(1, "R6");
    gap(1, "R6");
    expect_status(0, "R6");

    // R4: fourth set 128 columns after the first, run expired
    do_reset();
    col(LF_SET, 4'h1, "R4"); gap(42, "R4");
    col(LF_SET, 4'h1, "R4"); gap(42, "R4");
    col(LF_SET, 4'h1, "R4"); gap(41, "R4");
    col(LF_SET, 4'h1, "R4");
    expect_status(0, "R4");

    // R3: four remote sets back to back
    do_reset();
    for (int i = 0; i < 4; i++) col(RF_SET, 4'h1, "R3");
    expect_status(2, "R3");
    gap(5, "R8");
    expect_status(2, "R8");

    // R5: a set of the other type restarts the count
    do_reset();
    for (int i = 0; i < 3; i++) col(LF_SET, 4'h1, "R5");
    col(RF_SET, 4'h1, "R5");
    col(LF_SET, 4'h1, "R5");
    expect_status(0, "R5");
    for (int i = 0; i < 3; i++) col(LF_SET, 4'h1, "R5");
    expect_status(1, "R5");

    // R1: near-miss columns are not fault sets
    do_reset();
    for (int i = 0; i < 4; i++) col(LF_SET, 4'h3, "R1");
    for (int i = 0; i < 4; i++) col(32'h0101009C, 4'h1, "R1");
    for (int i = 0; i < 4; i++) col(32'h0300009C, 4'h1, "R1");
    for (int i = 0; i < 4; i++) col(32'h010000FB, 4'h1, "R1");
    for (int i = 0; i < 4; i++) col(32'h0201009C, 4'h1, "R1");
    expect_status(0, "R1");

    // R10: reset discards a partial run
    for (int i = 0; i < 3; i++) col(LF_SET, 4'h1, "R10");
    do_reset();
    col(LF_SET, 4'h1, "R10");
    expect_status(0, "R10");

    // Random mix of both fault types and idle stretches
    for (int blk = 0; blk < 120; blk++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 3) begin
        for (int j = 0; j < int'($urandom_range(1, 6)); j++)
          col(LF_SET, 4'h1, "R2");
      end else if (r < 6) begin
        for (int j = 0; j < int'($urandom_range(1, 6)); j++)
          col(RF_SET, 4'h1, "R3");
      end else if (r < 8) begin
        gap(int'($urandom_range(1, 60)), "R6");
      end else begin
        for (int j = 0; j < int'($urandom_range(1, 40)); j++)
          col($urandom, 4'($urandom), "R1");
      end
    end
    gap(130, "R6");
    expect_status(0, "R6");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule